// File: doc/BRIEF.md
# EPP Host Cycle Controller

This block connects a simple host I/O bus to a parallel port that runs enhanced parallel port (EPP 1.9) handshaked cycles. The host reads and writes eight byte-wide registers at offsets 0 to 7. Offsets 0 to 2 are the plain parallel-port registers: the data latch, the status register and the control register. These respond in the same cycle. Offset 3 is the EPP address port. Offsets 4 to 7 are four aliases of the EPP data port. When EPP mode is enabled, an access to offsets 3 to 7 starts a handshaked cycle on the parallel bus. The cycle drives nWriteOut, one of the two strobes and the bus direction, and it tracks the peripheral's nWait line through a synchroniser.

The host starts an access by raising hostWr or hostRd and holding the address and data stable. It holds the access until hostRdy reads high. For EPP offsets, hostRdy goes low in the same cycle that the access appears. It stays low until the peripheral accepts the byte or a watchdog gives up on the cycle. When a stalled cycle is aborted, bit 0 of the status register is set. The flag clears when a status read ends. The host must wait until nWait has returned low after a cycle before it issues the next EPP access.

When no handshaked cycle is driving the bus, three outputs follow control bits. The strobe output follows bit 0, the auto-feed output follows bit 1 and the init output follows bit 2. The bus direction follows bit 5 (the direction bit, 1 = input).

Top module: `eppHostPort`

## Requirements
- R1: After reset, hostRdy=1, nWriteOut=1, nDataStb=1, nAddrStb=1, pdOutEn=1, strobeOut=0, and status bit 0 reads 0.
- R2: Outside a handshaked cycle, the outputs follow the control register at offset 2: strobeOut = bit 0, autoFdOut = bit 1, initOut = bit 2, and pdOutEn = NOT bit 5. nWriteOut and both strobes stay high.
- R3: An access to offsets 3 to 7 in EPP mode drives hostRdy low in the cycle the access appears. hostRdy stays low for as long as either strobe is low.
- R4: If nWait is high when an EPP cycle starts, nWriteOut, nDataStb and nAddrStb do not change until nWait has been seen low.
- R5: A write cycle drives the data, sets pdOutEn=1 and pulls nWriteOut low one cycle before its strobe goes low. Offset 3 uses nAddrStb and offsets 4 to 7 use nDataStb. Only one strobe is ever low at a time.
- R6: When nWait goes high, the active strobe rises and hostRdy rises with it. nWriteOut and pdOut hold their values until nWait has been seen low again.
- R7: A read cycle keeps nWriteOut high and pdOutEn=0. It samples pdIn when nWait goes high. A host read of that offset returns the sampled byte.
- R8: If the strobe has not been released within CLK_MHZ*TIMEOUT_US clocks of the access starting, the cycle is aborted. The abort releases hostRdy and the strobes and sets status bit 0. Bit 0 clears when a status read ends.
- R9: While control bit 0 is 1, a handshaked cycle of either kind drives pdOutEn=1 and nWriteOut=0 while its strobe is low. The bus carries the last latched byte.
- R10: An EPP write issued while control bit 5 is 1 runs on the bus as a read (nWriteOut high, pdOutEn=0) and leaves status bit 0 at 0.
- R11: When eppEn=0, accesses to offsets 3 to 7 complete at once with no strobe, and reads of those offsets return 00h.
- R12: A write to offset 0 sets pdOut. A read of offset 0 returns pdIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eppEn | input | 1 | EPP mode enable |
| hostAddr | input | 3 | Register offset |
| hostWrData | input | 8 | Host write data |
| hostWr | input | 1 | Host write access, held until ready |
| hostRd | input | 1 | Host read access, held until ready |
| hostRdData | output | 8 | Host read data |
| hostRdy | output | 1 | Access may complete (low stretches the access) |
| pdOut | output | 8 | Parallel data out |
| pdIn | input | 8 | Parallel data in |
| pdOutEn | output | 1 | Parallel data output enable |
| nWriteOut | output | 1 | Active-low write indication |
| nDataStb | output | 1 | Active-low data strobe |
| nAddrStb | output | 1 | Active-low address strobe |
| nWaitIn | input | 1 | Peripheral handshake, asynchronous |
| strobeOut | output | 1 | Strobe control line |
| autoFdOut | output | 1 | Auto-feed control line |
| initOut | output | 1 | Init control line |

## Verification
The bound checker watches, on every cycle, that only one strobe is low at a time and that hostRdy stays low under a strobe. It also checks that nWriteOut already leads when a strobe falls, that nWriteOut is stable while a strobe is held, that the strobe override forces write direction, and that the lines are inactive when idle. The bench scenarios cover the behaviour that depends on what the peripheral does and on what the host sees later. This includes the setup wait while nWait is held high, the byte captured on reads, a write converted into a bus read by the direction bit, the length of the watchdog window and the clear-on-read flag, and the disabled-mode decode.

// File: rtl/eppHostPkg.sv
package eppHostPkg;
  localparam int OFF_W  = 3;
  localparam int DATA_W = 8;

  localparam logic [OFF_W-1:0] OFF_SPP_DATA = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STATUS   = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CONTROL  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_EPP_ADDR = 3'd3;

  localparam int CTL_STROBE = 0;
  localparam int CTL_AUTOFD = 1;
  localparam int CTL_INIT   = 2;
  localparam int CTL_DIRIN  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DRIVE,
    ST_STRB,
    ST_HOLD
  } eppState_e;

  typedef struct packed {
    logic loadLatch;
    logic capture;
    logic setTimeout;
  } eppStrobes_t;
endpackage

// File: rtl/eppSync.sv
module eppSync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic qOut
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    if (i == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) chain[0] <= RST_VAL;
        else       chain[0] <= dIn;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) chain[i] <= RST_VAL;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign qOut = chain[STAGES-1];
endmodule

// File: rtl/eppCtrl.sv
module eppCtrl
  import eppHostPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accStart,
  input  logic             accIsWr,
  input  logic [OFF_W-1:0] accOff,
  input  logic             eppEn,
  input  logic             dirInBit,
  input  logic             strbBit,
  input  logic             nWaitSync,
  output logic             hostRdy,
  output logic             nWriteOut,
  output logic             nDataStb,
  output logic             nAddrStb,
  output logic             busy,
  output logic             driveBus,
  output eppStrobes_t      stb
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  eppState_e        state, stateNxt;
  logic [CNT_W-1:0] cnt;
  logic             cycAddr, cycWrite;
  logic             eppHit, startCyc, inWait, expired;

  assign eppHit   = eppEn && (accOff >= OFF_EPP_ADDR);
  assign startCyc = accStart && eppHit && (state == ST_IDLE);
  assign inWait   = (state == ST_SETUP) || (state == ST_DRIVE) || (state == ST_STRB);
  assign expired  = inWait && (cnt == CNT_LAST);

  always_comb begin
    stateNxt       = state;
    stb.loadLatch  = 1'b0;
    stb.capture    = 1'b0;
    stb.setTimeout = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startCyc) begin
          stateNxt      = ST_SETUP;
          stb.loadLatch = accIsWr && !dirInBit;
        end
      end
      ST_SETUP: begin
        if (expired) begin
          stateNxt       = ST_IDLE;
          stb.setTimeout = 1'b1;
        end else if (!nWaitSync) begin
          stateNxt = ST_DRIVE;
        end
      end
      ST_DRIVE: begin
        if (expired) begin
          stateNxt       = ST_IDLE;
          stb.setTimeout = 1'b1;
        end else begin
          stateNxt = ST_STRB;
        end
      end
      ST_STRB: begin
        if (nWaitSync) begin
          stateNxt    = ST_HOLD;
          stb.capture = 1'b1;
        end else if (expired) begin
          stateNxt       = ST_IDLE;
          stb.setTimeout = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!nWaitSync) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cycAddr  <= 1'b0;
      cycWrite <= 1'b0;
    end else begin
      state <= stateNxt;
      if (startCyc) begin
        cnt      <= '0;
        cycAddr  <= (accOff == OFF_EPP_ADDR);
        cycWrite <= accIsWr && !dirInBit;
      end else if (inWait) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy      = (state == ST_DRIVE) || (state == ST_STRB) || (state == ST_HOLD);
  assign driveBus  = cycWrite || strbBit;
  assign nWriteOut = !(busy && driveBus);
  assign nDataStb  = !((state == ST_STRB) && !cycAddr);
  assign nAddrStb  = !((state == ST_STRB) && cycAddr);

  always_comb begin
    unique case (state)
      ST_IDLE: hostRdy = !(accStart && eppHit);
      ST_HOLD: hostRdy = 1'b1;
      default: hostRdy = 1'b0;
    endcase
  end
endmodule

// File: rtl/eppDatapath.sv
module eppDatapath
  import eppHostPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accStart,
  input  logic              accEnd,
  input  logic              accIsWr,
  input  logic [OFF_W-1:0]  accOff,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              eppEn,
  input  logic [DATA_W-1:0] pdIn,
  input  eppStrobes_t       stb,
  input  logic              busy,
  input  logic              driveBus,
  output logic [DATA_W-1:0] hostRdData,
  output logic [DATA_W-1:0] pdOut,
  output logic              pdOutEn,
  output logic              strobeOut,
  output logic              autoFdOut,
  output logic              initOut,
  output logic              dirInBit,
  output logic              strbBit
);
  logic [DATA_W-1:0] ctrlReg, pdLatch, rdCapture;
  logic              toFlag, lastRd;
  logic [OFF_W-1:0]  lastOff;
  logic              hostWrStart;

  assign hostWrStart = accStart && accIsWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      pdLatch   <= '0;
      rdCapture <= '0;
      toFlag    <= 1'b0;
      lastRd    <= 1'b0;
      lastOff   <= '0;
    end else begin
      if (accStart) begin
        lastOff <= accOff;
        lastRd  <= !accIsWr;
      end
      if (hostWrStart && accOff == OFF_CONTROL) ctrlReg <= hostWrData;
      if ((hostWrStart && accOff == OFF_SPP_DATA) || stb.loadLatch) pdLatch <= hostWrData;
      if (stb.capture) rdCapture <= pdIn;
      if (stb.setTimeout)                                   toFlag <= 1'b1;
      else if (accEnd && lastRd && lastOff == OFF_STATUS)   toFlag <= 1'b0;
    end
  end

  always_comb begin
    case (accOff)
      OFF_SPP_DATA: hostRdData = pdIn;
      OFF_STATUS:   hostRdData = {{(DATA_W-1){1'b0}}, toFlag};
      OFF_CONTROL:  hostRdData = ctrlReg;
      default:      hostRdData = eppEn ? rdCapture : '0;
    endcase
  end

  assign dirInBit  = ctrlReg[CTL_DIRIN];
  assign strbBit   = ctrlReg[CTL_STROBE];
  assign strobeOut = ctrlReg[CTL_STROBE];
  assign autoFdOut = ctrlReg[CTL_AUTOFD];
  assign initOut   = ctrlReg[CTL_INIT];
  assign pdOut     = pdLatch;
  assign pdOutEn   = busy ? driveBus : !dirInBit;
endmodule

// File: rtl/eppHostPort.sv
module eppHostPort
  import eppHostPkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int TIMEOUT_US  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eppEn,
  input  logic [OFF_W-1:0]  hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostWr,
  input  logic              hostRd,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostRdy,
  output logic [DATA_W-1:0] pdOut,
  input  logic [DATA_W-1:0] pdIn,
  output logic              pdOutEn,
  output logic              nWriteOut,
  output logic              nDataStb,
  output logic              nAddrStb,
  input  logic              nWaitIn,
  output logic              strobeOut,
  output logic              autoFdOut,
  output logic              initOut
);
  localparam int TIMEOUT_CYCLES = CLK_MHZ * TIMEOUT_US;

  logic        access, accPrev, accStart, accEnd;
  logic        nWaitSync, ctrlBusy, driveBus, dirInBit, strbBit;
  eppStrobes_t stb;

  assign access   = hostWr || hostRd;
  assign accStart = access && !accPrev;
  assign accEnd   = !access && accPrev;

  always_ff @(posedge clk) begin
    if (!rstN) accPrev <= 1'b0;
    else       accPrev <= access;
  end

  eppSync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) waitSyncI (
    .clk(clk), .rstN(rstN), .dIn(nWaitIn), .qOut(nWaitSync)
  );

  eppCtrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) ctrlI (
    .clk(clk), .rstN(rstN), .accStart(accStart), .accIsWr(hostWr),
    .accOff(hostAddr), .eppEn(eppEn), .dirInBit(dirInBit), .strbBit(strbBit),
    .nWaitSync(nWaitSync), .hostRdy(hostRdy), .nWriteOut(nWriteOut),
    .nDataStb(nDataStb), .nAddrStb(nAddrStb), .busy(ctrlBusy),
    .driveBus(driveBus), .stb(stb)
  );

  eppDatapath dpI (
    .clk(clk), .rstN(rstN), .accStart(accStart), .accEnd(accEnd),
    .accIsWr(hostWr), .accOff(hostAddr), .hostWrData(hostWrData),
    .eppEn(eppEn), .pdIn(pdIn), .stb(stb), .busy(ctrlBusy),
    .driveBus(driveBus), .hostRdData(hostRdData), .pdOut(pdOut),
    .pdOutEn(pdOutEn), .strobeOut(strobeOut), .autoFdOut(autoFdOut),
    .initOut(initOut), .dirInBit(dirInBit), .strbBit(strbBit)
  );
endmodule

// File: rtl/eppHostPortChk.sv
module eppHostPortChk (
  input logic clk,
  input logic rstN,
  input logic hostRdy,
  input logic nWriteOut,
  input logic nDataStb,
  input logic nAddrStb,
  input logic pdOutEn,
  input logic strobeOut,
  input logic ctrlBusy
);
  logic anyStb;
  assign anyStb = !nDataStb || !nAddrStb;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!nDataStb && !nAddrStb)); // R5

  AST_WRITE_LEADS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(anyStb) && !nWriteOut) |-> $past(!nWriteOut)); // R5

  AST_RDY_LOW_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    anyStb |-> !hostRdy); // R3

  AST_NWRITE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && $past(anyStb)) |-> $stable(nWriteOut)); // R6

  AST_RDY_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyStb) |-> hostRdy); // R6

  AST_OVERRIDE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && strobeOut) |-> (!nWriteOut && pdOutEn)); // R9

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBusy |-> (nWriteOut && nDataStb && nAddrStb)); // R2
endmodule

bind eppHostPort eppHostPortChk chkI (
  .clk(clk), .rstN(rstN), .hostRdy(hostRdy), .nWriteOut(nWriteOut),
  .nDataStb(nDataStb), .nAddrStb(nAddrStb), .pdOutEn(pdOutEn),
  .strobeOut(strobeOut), .ctrlBusy(ctrlBusy)
);

// File: tb/tb_eppHostPort.sv
`timescale 1ns/1ps
module tb_eppHostPort;
  localparam int CLK_MHZ  = 250;
  localparam int TO_US    = 10;
  localparam int TO_CYC   = CLK_MHZ * TO_US;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN, eppEn, hostWr, hostRd, hostRdy, pdOutEn;
  logic       nWriteOut, nDataStb, nAddrStb, nWaitIn, strobeOut, autoFdOut, initOut;
  logic [2:0] hostAddr;
  logic [7:0] hostWrData, hostRdData, pdOut, pdIn, periphByte;

  assign pdIn = periphByte;

  eppHostPort #(.CLK_MHZ(CLK_MHZ), .TIMEOUT_US(TO_US), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .eppEn(eppEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostWr(hostWr), .hostRd(hostRd),
    .hostRdData(hostRdData), .hostRdy(hostRdy), .pdOut(pdOut), .pdIn(pdIn),
    .pdOutEn(pdOutEn), .nWriteOut(nWriteOut), .nDataStb(nDataStb),
    .nAddrStb(nAddrStb), .nWaitIn(nWaitIn), .strobeOut(strobeOut),
    .autoFdOut(autoFdOut), .initOut(initOut)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Peripheral model, acts on falling clock edges
  bit stall = 0, holdHigh = 0, inStrb = 0, lastNWrLow = 0;
  bit seenWr, seenAddr, seenOe, prevNWrLow, termNWrLow, termRdy;
  logic [7:0] seenData;
  int dly = 0, strbCount = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      nWaitIn <= 1'b1;
      inStrb = 0;
      dly = 0;
    end else begin
      if (!nDataStb || !nAddrStb) begin
        if (!inStrb) begin
          inStrb = 1;
          strbCount++;
          seenWr = !nWriteOut;
          seenAddr = !nAddrStb;
          seenOe = pdOutEn;
          seenData = pdOut;
          prevNWrLow = lastNWrLow;
          dly = 0;
        end
        dly++;
        if (dly == 3 && !stall) nWaitIn <= 1'b1;
      end else begin
        if (inStrb) begin
          inStrb = 0;
          termNWrLow = !nWriteOut;
          termRdy = hostRdy;
        end
        if (holdHigh) nWaitIn <= 1'b1;
        else if (nWaitIn) nWaitIn <= 1'b0;
      end
    end
    lastNWrLow = !nWriteOut;
  end

  bit rdyAtStart;
  task automatic doAccess(input bit wr, input logic [2:0] off, input logic [7:0] d,
                          output logic [7:0] rd, output int cyc);
    @(negedge clk);
    hostAddr = off; hostWrData = d; hostWr = wr; hostRd = !wr; cyc = 0;
    #1;
    rdyAtStart = hostRdy;
    while (!hostRdy && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    rd = hostRdData;
    @(negedge clk);
    hostWr = 0; hostRd = 0;
    repeat (6) @(negedge clk);
  endtask

  typedef struct packed {
    bit       wr;
    bit [2:0] off;
    bit [7:0] wdata;
    bit [7:0] ctrl;
    bit [7:0] pin;
    bit       expNWr;
    bit       expAddr;
    bit       expOe;
    bit [7:0] expData;
    bit [7:0] expRd;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{1'b1, 3'd3, 8'h5A, 8'h04, 8'h00, 1'b1, 1'b1, 1'b1, 8'h5A, 8'h00},
    '{1'b1, 3'd4, 8'hC3, 8'h04, 8'h00, 1'b1, 1'b0, 1'b1, 8'hC3, 8'h00},
    '{1'b1, 3'd7, 8'h81, 8'h04, 8'h00, 1'b1, 1'b0, 1'b1, 8'h81, 8'h00},
    '{1'b0, 3'd4, 8'h00, 8'h04, 8'h3C, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C},
    '{1'b0, 3'd3, 8'h00, 8'h04, 8'h96, 1'b0, 1'b1, 1'b0, 8'h00, 8'h96},
    '{1'b1, 3'd5, 8'h11, 8'h24, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00},
    '{1'b0, 3'd6, 8'h00, 8'h05, 8'h77, 1'b1, 1'b0, 1'b1, 8'h81, 8'h77}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int cyc, cntSnap;
    rstN = 0; eppEn = 1; hostWr = 0; hostRd = 0; hostAddr = 0; hostWrData = 0;
    periphByte = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 hostRdy", hostRdy, 1);
    chk("R1 nWriteOut", nWriteOut, 1);
    chk("R1 nDataStb", nDataStb, 1);
    chk("R1 nAddrStb", nAddrStb, 1);
    chk("R1 pdOutEn", pdOutEn, 1);
    chk("R1 strobeOut", strobeOut, 0);
    doAccess(1'b0, 3'd1, 8'h00, rd, cyc);
    chk("R1 status", rd, 8'h00);

    // Vector table: handshaked cycles
    for (int i = 0; i < 7; i++) begin
      doAccess(1'b1, 3'd2, VECS[i].ctrl, rd, cyc);
      periphByte = VECS[i].pin;
      doAccess(VECS[i].wr, VECS[i].off, VECS[i].wdata, rd, cyc);
      chk("R3 hostRdy low at start", rdyAtStart, 0);
      chk(VECS[i].expNWr ? "R5/R9 nWrite seen low" : "R7/R10 nWrite seen high", seenWr, VECS[i].expNWr);
      chk("R5 strobe select", seenAddr, VECS[i].expAddr);
      chk("R7/R9/R10 bus direction", seenOe, VECS[i].expOe);
      if (VECS[i].expOe) chk("R5/R9 bus data", seenData, VECS[i].expData);
      if (VECS[i].wr && VECS[i].expNWr) chk("R5 nWrite leads strobe", prevNWrLow, 1);
      chk("R6 nWrite held at release", termNWrLow, VECS[i].expNWr);
      chk("R6 hostRdy at release", termRdy, 1);
      if (!VECS[i].wr) chk("R7 read data", rd, VECS[i].expRd);
      doAccess(1'b0, 3'd1, 8'h00, rd, cyc);
      chk("R10 no error flag", rd[0], 0);
    end

    // R2 passthrough
    doAccess(1'b1, 3'd2, 8'h27, rd, cyc);
    chk("R2 strobeOut", strobeOut, 1);
    chk("R2 autoFdOut", autoFdOut, 1);
    chk("R2 initOut", initOut, 1);
    chk("R2 pdOutEn input", pdOutEn, 0);
    doAccess(1'b1, 3'd2, 8'h00, rd, cyc);
    chk("R2 strobeOut clear", strobeOut, 0);
    chk("R2 pdOutEn output", pdOutEn, 1);
    doAccess(1'b1, 3'd2, 8'h04, rd, cyc);

    // R12 plain data register
    doAccess(1'b1, 3'd0, 8'hA5, rd, cyc);
    chk("R12 pdOut", pdOut, 8'hA5);
    periphByte = 8'h4E;
    doAccess(1'b0, 3'd0, 8'h00, rd, cyc);
    chk("R12 read pdIn", rd, 8'h4E);

    // R4 setup waits for nWait low
    holdHigh = 1;
    repeat (4) @(negedge clk);
    cntSnap = strbCount;
    fork
      doAccess(1'b1, 3'd4, 8'h3E, rd, cyc);
      begin
        repeat (20) @(negedge clk);
        chk("R4 nWrite idle while nWait high", nWriteOut, 1);
        chk("R4 no strobe while nWait high", strbCount - cntSnap, 0);
        chk("R4 hostRdy low while waiting", hostRdy, 0);
        holdHigh = 0;
      end
    join
    chk("R4 cycle completes", strbCount - cntSnap, 1);
    chk("R4 data", seenData, 8'h3E);

    // R8 watchdog
    stall = 1;
    doAccess(1'b1, 3'd4, 8'h66, rd, cyc);
    chk("R8 abort window", (cyc >= TO_CYC - 5 && cyc <= TO_CYC + 5), 1);
    chk("R8 strobe released", nDataStb, 1);
    stall = 0;
    doAccess(1'b0, 3'd1, 8'h00, rd, cyc);
    chk("R8 flag set", rd[0], 1);
    doAccess(1'b0, 3'd1, 8'h00, rd, cyc);
    chk("R8 flag cleared", rd[0], 0);

    // R11 disabled mode
    eppEn = 0;
    cntSnap = strbCount;
    doAccess(1'b1, 3'd4, 8'h99, rd, cyc);
    chk("R11 immediate ready", cyc, 0);
    chk("R11 no strobe", strbCount - cntSnap, 0);
    doAccess(1'b0, 3'd5, 8'h00, rd, cyc);
    chk("R11 read zero", rd, 8'h00);
    eppEn = 1;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule